// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Pool

This block holds instructions of an out-of-order core from the cycle they are issued until their results are written back. It is split into three groups: arithmetic (three entries feeding three single-cycle adders), multiply (two entries feeding two pipelined five-cycle multipliers) and memory (two entries feeding one address unit). Every issued instruction carries the number of its reorder-buffer slot as its result tag. Each source operand arrives either as a value or as the tag of the instruction that will produce it.

Each entry runs a four-state machine. FREE goes to WAIT on allocation when an operand is still missing, or straight to READY when both are present. WAIT goes to READY once the last missing operand has been taken from a result-bus lane whose tag matches. READY goes to EXEC when the selector grants it a functional unit. EXEC goes back to FREE when a result-bus lane carries the entry's own destination tag, which is its write-result cycle. Flush sends every state to FREE. Within a group, the ready entries are ranked by issue order. The oldest goes to the lowest-numbered unit that is accepting work, the next oldest to the next such unit, and so on.

Issue logic offers one instruction per cycle and holds it while the full indication for its group is high. Results come back over several result-bus lanes, each carrying a valid bit, a tag and a value.

Top module: `rs_pool`

## Requirements
- R1: After reset every entry is FREE: `iss_full` is low for kinds 0, 1 and 2, and no unit `*_go` bit is high.
- R2: `iss_kind` encodes 0 = add, 1 = multiply, 2 = memory. Kind 3 is reserved: `iss_full` is high for it and an offered instruction of kind 3 allocates nothing.
- R3: `iss_full` is high for the offered kind exactly when all entries of that group are busy (3 add, 2 multiply, 2 memory). An instruction is accepted in a cycle with `iss_valid` high and `iss_full` low.
- R4: An executing entry whose destination tag appears on any valid result lane becomes FREE at that clock edge. Its space counts as free from the next cycle.
- R5: A waiting operand takes the value from a valid result lane carrying its tag. The entry can be dispatched no earlier than the cycle after its last operand is taken.
- R6: A result broadcast in the same cycle as issue, carrying the tag of a missing source, is captured into the new entry. That entry then does not wait for the tag.
- R7: An entry is dispatched only when both operands are present and the target unit's `*_rdy` bit is high. In that cycle the unit's `*_go` is high and its op, destination tag and both operand values are presented.
- R8: The ready entries of a group are ranked oldest-issued first. Rank k goes to the k-th unit (ascending index) whose `*_rdy` is high, and at most one entry is dispatched per unit per cycle.
- R9: Each allocated entry is dispatched at most once. After dispatch it raises no further `*_go`.
- R10: `flush` returns every entry to FREE at the next edge. An issue or a result broadcast in the flush cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_kind | input | 2 | Group: 0 add, 1 multiply, 2 memory, 3 reserved |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | TAG_W | Result tag (reorder-buffer slot) |
| iss_a_rdy | input | 1 | Source A value present |
| iss_a_tag | input | TAG_W | Producer tag of source A |
| iss_a_val | input | DATA_W | Source A value |
| iss_b_rdy | input | 1 | Source B value present |
| iss_b_tag | input | TAG_W | Producer tag of source B |
| iss_b_val | input | DATA_W | Source B value |
| iss_full | output | 1 | No free entry for the offered kind |
| cdb_valid | input | CDB_N | Per-lane broadcast valid |
| cdb_tag | input | CDB_N*TAG_W | Per-lane result tag |
| cdb_val | input | CDB_N*DATA_W | Per-lane result value |
| add_rdy | input | ADD_U | Adder accepts an operation |
| add_go | output | ADD_U | Dispatch to adder |
| add_op | output | ADD_U*OP_W | Op per adder |
| add_dst | output | ADD_U*TAG_W | Result tag per adder |
| add_a | output | ADD_U*DATA_W | Operand A per adder |
| add_b | output | ADD_U*DATA_W | Operand B per adder |
| mul_rdy | input | MUL_U | Multiplier accepts an operation |
| mul_go | output | MUL_U | Dispatch to multiplier |
| mul_op | output | MUL_U*OP_W | Op per multiplier |
| mul_dst | output | MUL_U*TAG_W | Result tag per multiplier |
| mul_a | output | MUL_U*DATA_W | Operand A per multiplier |
| mul_b | output | MUL_U*DATA_W | Operand B per multiplier |
| mem_rdy | input | MEM_U | Address unit accepts an operation |
| mem_go | output | MEM_U | Dispatch to address unit |
| mem_op | output | MEM_U*OP_W | Op per address unit |
| mem_dst | output | MEM_U*TAG_W | Result tag per address unit |
| mem_a | output | MEM_U*DATA_W | Operand A per address unit |
| mem_b | output | MEM_U*DATA_W | Operand B per address unit |

## Verification
The bench builds the pool with its defaults: 3/2/2 entries, 3/2/1 units, two result lanes, 3-bit tags and 32-bit data. With three add entries and three adders, every adder can fire in one cycle. The memory group has two entries and a single address unit, so age order decides which entry goes first whenever both are ready. Random drops of the unit ready bits create the same contention in the other groups. Two result lanes allow a capture on one lane while the other frees an executing entry, and they allow the same-cycle forwarding at issue to be driven from either lane.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_EXEC  = 2'd3
    } rs_state_e;

    localparam logic [1:0] KIND_ADD = 2'd0;
    localparam logic [1:0] KIND_MUL = 2'd1;
    localparam logic [1:0] KIND_MEM = 2'd2;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int CDB_N  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    alloc,
    input  logic [OP_W-1:0]         in_op,
    input  logic [TAG_W-1:0]        in_dst,
    input  logic                    in_a_rdy,
    input  logic [TAG_W-1:0]        in_a_tag,
    input  logic [DATA_W-1:0]       in_a_val,
    input  logic                    in_b_rdy,
    input  logic [TAG_W-1:0]        in_b_tag,
    input  logic [DATA_W-1:0]       in_b_val,
    input  logic [CDB_N-1:0]        cdb_valid,
    input  logic [CDB_N*TAG_W-1:0]  cdb_tag,
    input  logic [CDB_N*DATA_W-1:0] cdb_val,
    input  logic                    grant,
    output logic                    busy,
    output logic                    ready,
    output logic [OP_W-1:0]         op,
    output logic [TAG_W-1:0]        dst,
    output logic [DATA_W-1:0]       a_val,
    output logic [DATA_W-1:0]       b_val
);
    rs_state_e state, nxt_state;

    logic              a_rdy_q, b_rdy_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q, dst_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;
    logic [OP_W-1:0]   op_q;

    logic              src_a_rdy, src_b_rdy, nxt_a_rdy, nxt_b_rdy;
    logic [TAG_W-1:0]  src_a_tag, src_b_tag;
    logic [DATA_W-1:0] src_a_val, src_b_val, nxt_a_val, nxt_b_val;
    logic              wb_hit;

    // Operand source: the issue bus while allocating, the stored copy otherwise.
    // Lanes are scanned high to low so the lowest matching lane wins.
    always_comb begin
        src_a_rdy = alloc ? in_a_rdy : a_rdy_q;
        src_a_tag = alloc ? in_a_tag : a_tag_q;
        src_a_val = alloc ? in_a_val : a_val_q;
        src_b_rdy = alloc ? in_b_rdy : b_rdy_q;
        src_b_tag = alloc ? in_b_tag : b_tag_q;
        src_b_val = alloc ? in_b_val : b_val_q;
        nxt_a_rdy = src_a_rdy;
        nxt_a_val = src_a_val;
        nxt_b_rdy = src_b_rdy;
        nxt_b_val = src_b_val;
        wb_hit    = 1'b0;
        for (int k = CDB_N - 1; k >= 0; k--) begin
            if (cdb_valid[k]) begin
                if (!src_a_rdy && cdb_tag[k*TAG_W +: TAG_W] == src_a_tag) begin
                    nxt_a_rdy = 1'b1;
                    nxt_a_val = cdb_val[k*DATA_W +: DATA_W];
                end
                if (!src_b_rdy && cdb_tag[k*TAG_W +: TAG_W] == src_b_tag) begin
                    nxt_b_rdy = 1'b1;
                    nxt_b_val = cdb_val[k*DATA_W +: DATA_W];
                end
                if (cdb_tag[k*TAG_W +: TAG_W] == dst_q) begin
                    wb_hit = 1'b1;
                end
            end
        end
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_FREE:  if (alloc) nxt_state = (nxt_a_rdy && nxt_b_rdy) ? ST_READY : ST_WAIT;
            ST_WAIT:  if (nxt_a_rdy && nxt_b_rdy) nxt_state = ST_READY;
            ST_READY: if (grant) nxt_state = ST_EXEC;
            ST_EXEC:  if (wb_hit) nxt_state = ST_FREE;
        endcase
        if (flush) nxt_state = ST_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FREE;
            op_q    <= '0;
            dst_q   <= '0;
            a_rdy_q <= 1'b0;
            a_tag_q <= '0;
            a_val_q <= '0;
            b_rdy_q <= 1'b0;
            b_tag_q <= '0;
            b_val_q <= '0;
        end else begin
            state   <= nxt_state;
            a_rdy_q <= nxt_a_rdy;
            a_tag_q <= src_a_tag;
            a_val_q <= nxt_a_val;
            b_rdy_q <= nxt_b_rdy;
            b_tag_q <= src_b_tag;
            b_val_q <= nxt_b_val;
            if (alloc) begin
                op_q  <= in_op;
                dst_q <= in_dst;
            end
        end
    end

    always_comb begin
        busy  = (state != ST_FREE);
        ready = (state == ST_READY);
        op    = op_q;
        dst   = dst_q;
        a_val = a_val_q;
        b_val = b_val_q;
    end

    // R7: a grant from the selector only lands on an entry holding both operands
    assert_grant_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (state == ST_READY));

    // R4: write-back of the entry's own tag while executing releases it
    assert_release_on_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && wb_hit && !flush) |=> (state == ST_FREE));

    // R10: flush empties the entry at the next edge
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == ST_FREE));

    // R9: a ready entry stays put until it is granted exactly once
    assert_ready_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && !grant && !flush) |=> (state == ST_READY));
endmodule

// File: rtl/rs_select.sv
module rs_select #(
    parameter int N = 3,
    parameter int U = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   alloc_oh,
    input  logic [N-1:0]   busy,
    input  logic [N-1:0]   ready,
    input  logic [U-1:0]   unit_rdy,
    output logic [U*N-1:0] sel,
    output logic [N-1:0]   grant
);
    localparam int MAXNU = (N > U) ? N : U;
    localparam int CW    = $clog2(MAXNU + 1);

    // older_q[i][j] set: entry j was issued before entry i
    logic [N-1:0]  older_q [N];
    logic [CW-1:0] rank    [N];
    logic [CW-1:0] urank   [U];
    logic [U-1:0]  selcol  [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc_oh[i])      older_q[i][j] <= busy[j];
                    else if (alloc_oh[j]) older_q[i][j] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rank[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (ready[j] && older_q[i][j]) rank[i] = rank[i] + CW'(1);
            end
        end
        for (int u = 0; u < U; u++) begin
            urank[u] = '0;
            for (int v = 0; v < u; v++) begin
                if (unit_rdy[v]) urank[u] = urank[u] + CW'(1);
            end
        end
        grant = '0;
        for (int u = 0; u < U; u++) begin
            for (int i = 0; i < N; i++) begin
                sel[u*N + i] = ready[i] && unit_rdy[u] && (rank[i] == urank[u]);
                selcol[i][u] = sel[u*N + i];
                if (sel[u*N + i]) grant[i] = 1'b1;
            end
        end
    end

    for (genvar gu = 0; gu < U; gu++) begin : g_unit_chk
        // R8: a unit takes at most one entry per cycle
        assert_one_entry_per_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(sel[gu*N +: N]));
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_entry_chk
        // R9: an entry never goes to two units at once
        assert_one_unit_per_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(selcol[gi]));
    end
endmodule

// File: rtl/rs_group.sv
module rs_group #(
    parameter int N      = 3,
    parameter int U      = 3,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int CDB_N  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    alloc_req,
    input  logic [OP_W-1:0]         in_op,
    input  logic [TAG_W-1:0]        in_dst,
    input  logic                    in_a_rdy,
    input  logic [TAG_W-1:0]        in_a_tag,
    input  logic [DATA_W-1:0]       in_a_val,
    input  logic                    in_b_rdy,
    input  logic [TAG_W-1:0]        in_b_tag,
    input  logic [DATA_W-1:0]       in_b_val,
    input  logic [CDB_N-1:0]        cdb_valid,
    input  logic [CDB_N*TAG_W-1:0]  cdb_tag,
    input  logic [CDB_N*DATA_W-1:0] cdb_val,
    input  logic [U-1:0]            unit_rdy,
    output logic                    full,
    output logic [U-1:0]            unit_go,
    output logic [U*OP_W-1:0]       unit_op,
    output logic [U*TAG_W-1:0]      unit_dst,
    output logic [U*DATA_W-1:0]     unit_a,
    output logic [U*DATA_W-1:0]     unit_b
);
    logic [N-1:0]      busy, ready, grant, free_vec, alloc_oh;
    logic [U*N-1:0]    sel;
    logic [OP_W-1:0]   e_op  [N];
    logic [TAG_W-1:0]  e_dst [N];
    logic [DATA_W-1:0] e_a   [N];
    logic [DATA_W-1:0] e_b   [N];

    // lowest-index free entry takes the new instruction
    always_comb begin
        free_vec = ~busy;
        full     = &busy;
        alloc_oh = (alloc_req && !full) ? (free_vec & ~(free_vec - N'(1))) : '0;
    end

    for (genvar g = 0; g < N; g++) begin : g_ent
        rs_entry #(
            .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .CDB_N(CDB_N)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .alloc     (alloc_oh[g]),
            .in_op     (in_op),
            .in_dst    (in_dst),
            .in_a_rdy  (in_a_rdy),
            .in_a_tag  (in_a_tag),
            .in_a_val  (in_a_val),
            .in_b_rdy  (in_b_rdy),
            .in_b_tag  (in_b_tag),
            .in_b_val  (in_b_val),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_val   (cdb_val),
            .grant     (grant[g]),
            .busy      (busy[g]),
            .ready     (ready[g]),
            .op        (e_op[g]),
            .dst       (e_dst[g]),
            .a_val     (e_a[g]),
            .b_val     (e_b[g])
        );
    end

    rs_select #(.N(N), .U(U)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_oh (alloc_oh),
        .busy     (busy),
        .ready    (ready),
        .unit_rdy (unit_rdy),
        .sel      (sel),
        .grant    (grant)
    );

    always_comb begin
        unit_go  = '0;
        unit_op  = '0;
        unit_dst = '0;
        unit_a   = '0;
        unit_b   = '0;
        for (int u = 0; u < U; u++) begin
            for (int i = 0; i < N; i++) begin
                if (sel[u*N + i]) begin
                    unit_go[u]                  = 1'b1;
                    unit_op[u*OP_W +: OP_W]     = e_op[i];
                    unit_dst[u*TAG_W +: TAG_W]  = e_dst[i];
                    unit_a[u*DATA_W +: DATA_W]  = e_a[i];
                    unit_b[u*DATA_W +: DATA_W]  = e_b[i];
                end
            end
        end
    end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int CDB_N  = 2,
    parameter int ADD_N  = 3,
    parameter int ADD_U  = 3,
    parameter int MUL_N  = 2,
    parameter int MUL_U  = 2,
    parameter int MEM_N  = 2,
    parameter int MEM_U  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    iss_valid,
    input  logic [1:0]              iss_kind,
    input  logic [OP_W-1:0]         iss_op,
    input  logic [TAG_W-1:0]        iss_dst,
    input  logic                    iss_a_rdy,
    input  logic [TAG_W-1:0]        iss_a_tag,
    input  logic [DATA_W-1:0]       iss_a_val,
    input  logic                    iss_b_rdy,
    input  logic [TAG_W-1:0]        iss_b_tag,
    input  logic [DATA_W-1:0]       iss_b_val,
    output logic                    iss_full,
    input  logic [CDB_N-1:0]        cdb_valid,
    input  logic [CDB_N*TAG_W-1:0]  cdb_tag,
    input  logic [CDB_N*DATA_W-1:0] cdb_val,
    input  logic [ADD_U-1:0]        add_rdy,
    output logic [ADD_U-1:0]        add_go,
    output logic [ADD_U*OP_W-1:0]   add_op,
    output logic [ADD_U*TAG_W-1:0]  add_dst,
    output logic [ADD_U*DATA_W-1:0] add_a,
    output logic [ADD_U*DATA_W-1:0] add_b,
    input  logic [MUL_U-1:0]        mul_rdy,
    output logic [MUL_U-1:0]        mul_go,
    output logic [MUL_U*OP_W-1:0]   mul_op,
    output logic [MUL_U*TAG_W-1:0]  mul_dst,
    output logic [MUL_U*DATA_W-1:0] mul_a,
    output logic [MUL_U*DATA_W-1:0] mul_b,
    input  logic [MEM_U-1:0]        mem_rdy,
    output logic [MEM_U-1:0]        mem_go,
    output logic [MEM_U*OP_W-1:0]   mem_op,
    output logic [MEM_U*TAG_W-1:0]  mem_dst,
    output logic [MEM_U*DATA_W-1:0] mem_a,
    output logic [MEM_U*DATA_W-1:0] mem_b
);
    logic add_full, mul_full, mem_full;
    logic add_req, mul_req, mem_req;

    always_comb begin
        add_req = iss_valid && (iss_kind == KIND_ADD);
        mul_req = iss_valid && (iss_kind == KIND_MUL);
        mem_req = iss_valid && (iss_kind == KIND_MEM);
        unique case (iss_kind)
            KIND_ADD: iss_full = add_full;
            KIND_MUL: iss_full = mul_full;
            KIND_MEM: iss_full = mem_full;
            default:  iss_full = 1'b1;
        endcase
    end

    rs_group #(.N(ADD_N), .U(ADD_U), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .CDB_N(CDB_N)) u_add (
        .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_req(add_req),
        .in_op(iss_op), .in_dst(iss_dst),
        .in_a_rdy(iss_a_rdy), .in_a_tag(iss_a_tag), .in_a_val(iss_a_val),
        .in_b_rdy(iss_b_rdy), .in_b_tag(iss_b_tag), .in_b_val(iss_b_val),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
        .unit_rdy(add_rdy), .full(add_full), .unit_go(add_go), .unit_op(add_op),
        .unit_dst(add_dst), .unit_a(add_a), .unit_b(add_b)
    );

    rs_group #(.N(MUL_N), .U(MUL_U), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .CDB_N(CDB_N)) u_mul (
        .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_req(mul_req),
        .in_op(iss_op), .in_dst(iss_dst),
        .in_a_rdy(iss_a_rdy), .in_a_tag(iss_a_tag), .in_a_val(iss_a_val),
        .in_b_rdy(iss_b_rdy), .in_b_tag(iss_b_tag), .in_b_val(iss_b_val),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
        .unit_rdy(mul_rdy), .full(mul_full), .unit_go(mul_go), .unit_op(mul_op),
        .unit_dst(mul_dst), .unit_a(mul_a), .unit_b(mul_b)
    );

    rs_group #(.N(MEM_N), .U(MEM_U), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .CDB_N(CDB_N)) u_mem (
        .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_req(mem_req),
        .in_op(iss_op), .in_dst(iss_dst),
        .in_a_rdy(iss_a_rdy), .in_a_tag(iss_a_tag), .in_a_val(iss_a_val),
        .in_b_rdy(iss_b_rdy), .in_b_tag(iss_b_tag), .in_b_val(iss_b_val),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
        .unit_rdy(mem_rdy), .full(mem_full), .unit_go(mem_go), .unit_op(mem_op),
        .unit_dst(mem_dst), .unit_a(mem_a), .unit_b(mem_b)
    );
endmodule

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        iv = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [3:0]  op = '0;
    logic [2:0]  dst = '0, atag = '0, btag = '0, ct0 = '0, ct1 = '0;
    logic        ardy = 1'b1, brdy = 1'b1;
    logic [31:0] aval = '0, bval = '0, cval0 = '0, cval1 = '0;
    logic [1:0]  cv = '0;
    logic [2:0]  add_rdy = '0;
    logic [1:0]  mul_rdy = '0;
    logic [0:0]  mem_rdy = '0;

    logic        iss_full;
    logic [2:0]  add_go;  logic [11:0] add_op; logic [8:0] add_dst; logic [95:0] add_a, add_b;
    logic [1:0]  mul_go;  logic [7:0]  mul_op; logic [5:0] mul_dst; logic [63:0] mul_a, mul_b;
    logic [0:0]  mem_go;  logic [3:0]  mem_op; logic [2:0] mem_dst; logic [31:0] mem_a, mem_b;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    rs_pool u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iv), .iss_kind(kind), .iss_op(op), .iss_dst(dst),
        .iss_a_rdy(ardy), .iss_a_tag(atag), .iss_a_val(aval),
        .iss_b_rdy(brdy), .iss_b_tag(btag), .iss_b_val(bval),
        .iss_full(iss_full),
        .cdb_valid(cv), .cdb_tag({ct1, ct0}), .cdb_val({cval1, cval0}),
        .add_rdy(add_rdy), .add_go(add_go), .add_op(add_op), .add_dst(add_dst), .add_a(add_a), .add_b(add_b),
        .mul_rdy(mul_rdy), .mul_go(mul_go), .mul_op(mul_op), .mul_dst(mul_dst), .mul_a(mul_a), .mul_b(mul_b),
        .mem_rdy(mem_rdy), .mem_go(mem_go), .mem_op(mem_op), .mem_dst(mem_dst), .mem_a(mem_a), .mem_b(mem_b)
    );

    // behavioural model: per group a set of slots; 0 free, 1 waiting, 2 ready, 3 executing
    int m_st [3][3];
    int m_stamp [3][3];
    int m_op [3][3];
    int m_dst [3][3];
    int m_ar [3][3];
    int m_at [3][3];
    int m_av [3][3];
    int m_br [3][3];
    int m_bt [3][3];
    int m_bv [3][3];
    int exp_slot [3][3];
    int seq = 0;

    function automatic int ns(int c); return (c == 0) ? 3 : 2; endfunction
    function automatic int nu(int c); return (c == 0) ? 3 : ((c == 1) ? 2 : 1); endfunction

    function automatic bit urdy(int c, int u);
        if (c == 0) return add_rdy[u];
        if (c == 1) return mul_rdy[u];
        return mem_rdy[u];
    endfunction

    function automatic bit grp_full(int c);
        for (int s = 0; s < ns(c); s++) if (m_st[c][s] == 0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit lane_hit(int t);
        return (cv[0] && int'(ct0) == t) || (cv[1] && int'(ct1) == t);
    endfunction

    task automatic snoop(inout int r, inout int v, input int t);
        if (r == 0) begin
            if (cv[0] && int'(ct0) == t) begin r = 1; v = int'(cval0); end
            else if (cv[1] && int'(ct1) == t) begin r = 1; v = int'(cval1); end
        end
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input string lbl);
        int ef;
        bit taken [3][3];
        #1;
        ef = (kind == 2'd3) ? 1 : int'(grp_full(int'(kind)));
        check(lbl, "iss_full", int'(iss_full), ef);
        for (int c = 0; c < 3; c++) for (int s = 0; s < 3; s++) taken[c][s] = 1'b0;
        for (int c = 0; c < 3; c++) begin
            for (int u = 0; u < nu(c); u++) begin
                int best;
                int ag, ao, ad, aa, ab;
                best = -1;
                if (urdy(c, u)) begin
                    for (int s = 0; s < ns(c); s++) begin
                        if (m_st[c][s] == 2 && !taken[c][s] &&
                            (best < 0 || m_stamp[c][s] < m_stamp[c][best])) best = s;
                    end
                end
                exp_slot[c][u] = best;
                if (best >= 0) taken[c][best] = 1'b1;
                if (c == 0) begin
                    ag = int'(add_go[u]); ao = int'(add_op[u*4 +: 4]); ad = int'(add_dst[u*3 +: 3]);
                    aa = int'(add_a[u*32 +: 32]); ab = int'(add_b[u*32 +: 32]);
                end else if (c == 1) begin
                    ag = int'(mul_go[u]); ao = int'(mul_op[u*4 +: 4]); ad = int'(mul_dst[u*3 +: 3]);
                    aa = int'(mul_a[u*32 +: 32]); ab = int'(mul_b[u*32 +: 32]);
                end else begin
                    ag = int'(mem_go[u]); ao = int'(mem_op[u*4 +: 4]); ad = int'(mem_dst[u*3 +: 3]);
                    aa = int'(mem_a[u*32 +: 32]); ab = int'(mem_b[u*32 +: 32]);
                end
                check(lbl, "go", ag, (best >= 0) ? 1 : 0);
                if (best >= 0 && ag == 1) begin
                    check(lbl, "op", ao, m_op[c][best]);
                    check(lbl, "dst", ad, m_dst[c][best]);
                    check(lbl, "operand a", aa, m_av[c][best]);
                    check(lbl, "operand b", ab, m_bv[c][best]);
                end
            end
        end
        @(posedge clk);
        if (flush) begin
            for (int c = 0; c < 3; c++) for (int s = 0; s < 3; s++) m_st[c][s] = 0;
        end else begin
            bit acc;
            int k, slot;
            k = int'(kind);
            acc = iv && (kind != 2'd3) && !grp_full(k);
            slot = -1;
            if (acc) for (int s = ns(k) - 1; s >= 0; s--) if (m_st[k][s] == 0) slot = s;
            for (int c = 0; c < 3; c++) begin
                for (int s = 0; s < ns(c); s++) begin
                    if (m_st[c][s] == 3 && lane_hit(m_dst[c][s])) m_st[c][s] = 0;
                    else if (m_st[c][s] == 1) begin
                        snoop(m_ar[c][s], m_av[c][s], m_at[c][s]);
                        snoop(m_br[c][s], m_bv[c][s], m_bt[c][s]);
                        if (m_ar[c][s] != 0 && m_br[c][s] != 0) m_st[c][s] = 2;
                    end
                end
                for (int u = 0; u < nu(c); u++) if (exp_slot[c][u] >= 0) m_st[c][exp_slot[c][u]] = 3;
            end
            if (slot >= 0) begin
                m_op[k][slot] = int'(op);   m_dst[k][slot] = int'(dst);
                m_ar[k][slot] = int'(ardy); m_at[k][slot] = int'(atag); m_av[k][slot] = int'(aval);
                m_br[k][slot] = int'(brdy); m_bt[k][slot] = int'(btag); m_bv[k][slot] = int'(bval);
                snoop(m_ar[k][slot], m_av[k][slot], m_at[k][slot]);
                snoop(m_br[k][slot], m_bv[k][slot], m_bt[k][slot]);
                m_st[k][slot] = (m_ar[k][slot] != 0 && m_br[k][slot] != 0) ? 2 : 1;
                m_stamp[k][slot] = seq;
                seq++;
            end
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        iv = 1'b0; cv = 2'b00; flush = 1'b0;
    endtask

    task automatic put(input logic [1:0] k, input int d, input bit ar, input int at, input int av,
                       input bit br, input int bt, input int bv);
        iv = 1'b1; kind = k; op = 4'(d + 3); dst = 3'(d);
        ardy = ar; atag = 3'(at); aval = 32'(av);
        brdy = br; btag = 3'(bt); bval = 32'(bv);
    endtask

    task automatic bcast(input int lane, input int t, input int v);
        if (lane == 0) begin cv[0] = 1'b1; ct0 = 3'(t); cval0 = 32'(v); end
        else begin cv[1] = 1'b1; ct1 = 3'(t); cval1 = 32'(v); end
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(7));
        for (int c = 0; c < 3; c++) for (int s = 0; s < 3; s++) begin
            m_st[c][s] = 0; m_stamp[c][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty pool after reset, every kind has room, nothing dispatched
        add_rdy = '1; mul_rdy = '1; mem_rdy = '1;
        for (int k = 0; k < 3; k++) begin quiet(); kind = 2'(k); cyc("R1"); end

        // R2: reserved kind reports full and allocates nothing
        put(2'd3, 1, 1, 0, 32'h11, 1, 0, 32'h22); cyc("R2");
        quiet(); kind = 2'd0; cyc("R2"); cyc("R2");

        // R3: three adds waiting on tag 5 fill the group, a fourth is refused
        add_rdy = '1;
        for (int i = 0; i < 4; i++) begin put(2'd0, i, 0, 5, 0, 1, 0, 100 + i); cyc("R3"); end
        quiet(); kind = 2'd0; cyc("R3");

        // R5: tag 5 broadcast wakes all three; dispatch the cycle after
        bcast(1, 5, 32'h55); cyc("R5");
        quiet(); cyc("R5"); cyc("R8");

        // R4: write-back of tags 0 and 1 frees two entries, room visible next cycle
        bcast(0, 0, 1); bcast(1, 1, 2); cyc("R4");
        quiet(); kind = 2'd0; cyc("R4");
        bcast(0, 2, 3); cyc("R4"); quiet(); cyc("R4");

        // R6: source tag broadcast in the issue cycle is captured at once
        put(2'd1, 4, 0, 6, 0, 1, 0, 7); bcast(0, 6, 32'h44); cyc("R6");
        quiet(); kind = 2'd1; cyc("R6"); cyc("R6");
        bcast(1, 4, 9); cyc("R6"); quiet(); cyc("R6");

        // R7: memory op with a missing operand never dispatches until it arrives
        put(2'd2, 2, 1, 0, 32'hA0, 0, 3, 0); cyc("R7");
        quiet(); kind = 2'd2; repeat (3) cyc("R7");
        bcast(0, 3, 32'h33); cyc("R7"); quiet(); cyc("R7");
        bcast(0, 2, 0); cyc("R7"); quiet(); cyc("R7");

        // R8: two ready memory ops, unit blocked, then released: oldest first
        mem_rdy = '0;
        put(2'd2, 5, 1, 0, 32'hB1, 1, 0, 32'hC1); cyc("R8");
        put(2'd2, 1, 1, 0, 32'hB2, 1, 0, 32'hC2); cyc("R8");
        quiet(); kind = 2'd2; cyc("R8");
        mem_rdy = '1; cyc("R8"); cyc("R8");

        // R9: dispatched entries do not fire again while units stay open
        repeat (3) cyc("R9");
        bcast(0, 5, 0); bcast(1, 1, 0); cyc("R9"); quiet(); cyc("R9");

        // R10: flush with a concurrent issue and broadcast clears everything
        put(2'd0, 0, 0, 7, 0, 1, 0, 1); cyc("R10");
        put(2'd0, 1, 0, 7, 0, 1, 0, 2); cyc("R10");
        put(2'd0, 2, 0, 7, 0, 1, 0, 3); flush = 1'b1; bcast(0, 7, 32'h77); cyc("R10");
        quiet(); kind = 2'd0; cyc("R10");
        bcast(0, 7, 32'h78); cyc("R10"); quiet(); cyc("R10"); cyc("R10");

        // mixed traffic against the model; unit ready drops create contention (R8)
        for (int n = 0; n < 600; n++) begin
            int t;
            quiet();
            iv = ($urandom % 3) != 0;
            kind = 2'($urandom % 4);
            op = 4'($urandom);
            dst = 3'($urandom % 6);
            ardy = ($urandom % 2) != 0; atag = 3'($urandom); aval = $urandom;
            brdy = ($urandom % 2) != 0; btag = 3'($urandom); bval = $urandom;
            t = int'($urandom % 8);
            cv = 2'($urandom);
            ct0 = 3'(t); ct1 = 3'((t + 1) % 8);
            cval0 = $urandom; cval1 = $urandom;
            add_rdy = 3'($urandom); mul_rdy = 2'($urandom); mem_rdy = 1'($urandom);
            flush = ($urandom % 40) == 0;
            cyc("R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule